// File: doc/BRIEF.md
# Receive FIFO Watermark Drain Controller

This block manages the receive buffer of one channel. The buffer is a ring of a fixed number of equal-sized blocks. A framing engine pushes bytes into it, and each byte carries an end-of-frame flag. The controller decides when to ask a DMA engine to move the buffered data toward the host. It counts whole blocks filled since the last drain, not bytes. It raises a request when that count reaches a programmed block watermark, or as soon as an end-of-frame byte is written.

After the DMA accepts the request, the controller opens its read port. The DMA then pops bytes until the buffer is completely empty. End-of-frame bytes in the stored data do not stop the drain, and every popped byte comes out with its end-of-frame flag. When the buffer runs dry, the request drops and block counting starts again from zero. The partially filled block that was in progress is kept.

Top module: `rxwm_dma_trig`

## Requirements
- R1: After reset, `dma_req`, `rd_valid` and `overflow` are low.
- R2: With no end-of-frame written, `dma_req` rises in the cycle after the write that completes the W-th whole block since the last drain. W is the effective watermark in blocks, and a block is BLK_BYTES consecutive accepted writes.
- R3: While fewer than W whole blocks have been completed and no end-of-frame byte has been written, `dma_req` stays low.
- R4: An accepted write with `wr_eof`=1 raises `dma_req` in the next cycle, whatever the block count.
- R5: Once raised, `dma_req` stays high until the DMA has pulsed `dma_ack` and the buffer has then become empty. It drops one cycle after the buffer is empty, provided no write arrives in that cycle.
- R6: Popped bytes leave in write order, and each one keeps the end-of-frame flag it was written with.
- R7: A drain does not stop at end-of-frame bytes. It goes on until every stored byte has been popped.
- R8: `rd_valid` is high only after `dma_ack` has been seen, only while the buffer holds data, and only while `dma_req` is high. A `rd_pop` issued at any other time has no effect.
- R9: After a drain ends, the block count restarts at zero, and another W whole blocks (or an end-of-frame) are needed before the next request.
- R10: A `cfg_hiwm` value outside 1 to NUM_BLKS-1 sets `cfg_error`, and such a value acts as NUM_BLKS-1. A legal value clears `cfg_error` and is used as given.
- R11: A write to a full buffer (NUM_BLKS*BLK_BYTES bytes stored) is dropped and sets `overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hiwm | input | WM_W | Watermark in whole blocks |
| cfg_error | output | 1 | Watermark setting out of range |
| wr_en | input | 1 | Write strobe from the framing engine |
| wr_data | input | DATA_W | Byte to store |
| wr_eof | input | 1 | The byte ends a frame |
| overflow | output | 1 | Sticky: a write was dropped because the buffer was full |
| dma_req | output | 1 | Drain request to the DMA |
| dma_ack | input | 1 | DMA accepts the request (one-cycle pulse) |
| rd_pop | input | 1 | DMA takes the byte at the head |
| rd_valid | output | 1 | Head byte is available for popping |
| rd_data | output | DATA_W | Head byte |
| rd_eof | output | 1 | End-of-frame flag of the head byte |

## Verification
The watermark path is tried in two ways. A long stream with no end-of-frame is written, and the request is checked one write before and one write after the block boundary that reaches the watermark. This shows that the trigger counts whole blocks and not bytes. The same stream is repeated after a drain, starting in the middle of a block, so a count that failed to restart shows up. A short frame that ends early separates the end-of-frame trigger from the block trigger. Legal and clamped watermark settings show whether the configured value or the clamp value is in force. A full-buffer stream with extra writes, drained with end-of-frame bytes in the middle, shows that dropped bytes never come out and that the drain does not stop early.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REQ   = 2'd1,
      ST_DRAIN = 2'd2
   } drain_state_e;
endpackage

// File: rtl/rxwm_cfg.sv
// Watermark legality check and clamp (R10).
module rxwm_cfg #(
   parameter int NUM_BLKS = 4,
   parameter int WM_W     = 3
) (
   input  logic [WM_W-1:0] cfg_wm,
   output logic [WM_W-1:0] wm_eff,
   output logic            cfg_err
);
   localparam logic [WM_W-1:0] WM_MAX = WM_W'(NUM_BLKS - 1);

   always_comb begin
      cfg_err = (cfg_wm == '0) || (cfg_wm > WM_MAX);
      wm_eff  = cfg_err ? WM_MAX : cfg_wm;
   end
endmodule

// File: rtl/rxwm_ring.sv
// Byte ring with one end-of-frame flag per entry.
module rxwm_ring #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic [DATA_W:0]            din,
   output logic [DATA_W:0]            dout,
   output logic [$clog2(DEPTH+1)-1:0] fill
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DATA_W:0]  mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic [CNT_W-1:0] cnt_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_nx;
         if (pop)  rp_q <= rp_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout = mem[rp_q];
   assign fill = cnt_q;
endmodule

// File: rtl/rxwm_blk_track.sv
// Counts whole blocks written since the last drain and flags a trigger.
module rxwm_blk_track #(
   parameter int BLK_BYTES = 16,
   parameter int WM_W      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_acc,
   input  logic            wr_eof,
   input  logic            clr,
   input  logic [WM_W-1:0] wm_eff,
   output logic            trig
);
   localparam int OFF_W = $clog2(BLK_BYTES);

   logic [OFF_W-1:0] off_q;
   logic [WM_W-1:0]  blk_q;
   logic             blk_end;
   logic [WM_W:0]    blk_inc;

   assign blk_end = (off_q == OFF_W'(BLK_BYTES - 1));
   assign blk_inc = {1'b0, blk_q} + 1'b1;
   assign trig    = wr_acc && (wr_eof || (blk_end && (blk_inc >= {1'b0, wm_eff})));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q <= '0;
         blk_q <= '0;
      end else begin
         if (wr_acc) off_q <= blk_end ? '0 : off_q + 1'b1;
         if (clr)
            blk_q <= '0;
         else if (wr_acc && blk_end && (blk_q != '1))
            blk_q <= blk_q + 1'b1;
      end
   end
endmodule

// File: rtl/rxwm_dma_trig.sv
module rxwm_dma_trig
   import rxwm_pkg::*;
#(
   parameter int BLK_BYTES = 16,
   parameter int NUM_BLKS  = 4,
   parameter int DATA_W    = 8,
   parameter int WM_W      = $clog2(NUM_BLKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WM_W-1:0]   cfg_hiwm,
   output logic              cfg_error,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eof,
   output logic              overflow,
   output logic              dma_req,
   input  logic              dma_ack,
   input  logic              rd_pop,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_eof
);
   localparam int DEPTH = BLK_BYTES * NUM_BLKS;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (NUM_BLKS < 2)        begin : g_bad_blks  $error("NUM_BLKS must be at least 2");  end
      if (BLK_BYTES < 2)       begin : g_bad_size  $error("BLK_BYTES must be at least 2"); end
      if (DATA_W < 1)          begin : g_bad_width $error("DATA_W must be positive");      end
      if ((1 << WM_W) <= NUM_BLKS) begin : g_bad_wm $error("WM_W too narrow for NUM_BLKS"); end
   endgenerate

   drain_state_e     st_q;
   logic [CNT_W-1:0] fill_cnt;
   logic             full, wr_acc, pop, trig, clr, ovf_q;
   logic [WM_W-1:0]  wm_eff;
   logic [DATA_W:0]  head;

   assign full     = (fill_cnt == CNT_W'(DEPTH));
   assign wr_acc   = wr_en && !full;
   assign rd_valid = (st_q == ST_DRAIN) && (fill_cnt != '0);
   assign pop      = rd_pop && rd_valid;
   assign clr      = (st_q == ST_DRAIN) && (fill_cnt == '0) && !wr_acc;

   rxwm_cfg #(.NUM_BLKS(NUM_BLKS), .WM_W(WM_W)) u_cfg (
      .cfg_wm  (cfg_hiwm),
      .wm_eff  (wm_eff),
      .cfg_err (cfg_error)
   );

   rxwm_blk_track #(.BLK_BYTES(BLK_BYTES), .WM_W(WM_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_acc (wr_acc),
      .wr_eof (wr_eof),
      .clr    (clr),
      .wm_eff (wm_eff),
      .trig   (trig)
   );

   rxwm_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_acc),
      .pop   (pop),
      .din   ({wr_eof, wr_data}),
      .dout  (head),
      .fill  (fill_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ovf_q <= 1'b0;
      end else begin
         if (wr_en && full) ovf_q <= 1'b1;
         case (st_q)
            ST_IDLE:  if (trig)    st_q <= ST_REQ;
            ST_REQ:   if (dma_ack) st_q <= ST_DRAIN;
            ST_DRAIN: if (clr)     st_q <= ST_IDLE;
            default:               st_q <= ST_IDLE;
         endcase
      end
   end

   assign dma_req  = (st_q != ST_IDLE);
   assign overflow = ovf_q;
   assign rd_data  = head[DATA_W-1:0];
   assign rd_eof   = head[DATA_W];
endmodule

// File: rtl/rxwm_chk.sv
module rxwm_chk #(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_eof,
   input logic             rd_pop,
   input logic             rd_valid,
   input logic             rd_eof,
   input logic             dma_req,
   input logic             overflow,
   input logic             full,
   input logic [CNT_W-1:0] fill
);
   a_r8_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> dma_req);

   a_r5_req_drops_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) |-> (fill == '0));

   a_r4_eof_requests: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_eof && !full) |=> dma_req);

   a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !(rd_pop && rd_valid)) |=> (fill == $past(fill)));

   a_r7_past_eof: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_pop && rd_eof && (fill > 1) && !wr_en) |=> rd_valid);
endmodule

bind rxwm_dma_trig rxwm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_eof   (wr_eof),
   .rd_pop   (rd_pop),
   .rd_valid (rd_valid),
   .rd_eof   (rd_eof),
   .dma_req  (dma_req),
   .overflow (overflow),
   .full     (full),
   .fill     (fill_cnt)
);

// File: tb/rxwm_dma_trig_tb.sv
module rxwm_dma_trig_tb;
   localparam int BLK   = 16;
   localparam int NB    = 4;
   localparam int DW    = 8;
   localparam int WMW   = 3;
   localparam int DEPTH = BLK * NB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WMW-1:0] cfg_hiwm = 3'd3;
   logic          cfg_error, overflow, dma_req, rd_valid, rd_eof;
   logic          wr_en = 1'b0, wr_eof = 1'b0, dma_ack = 1'b0, rd_pop = 1'b0;
   logic [DW-1:0] wr_data = '0, rd_data;

   int            n_chk = 0, n_err = 0, m_fill = 0;
   logic [DW:0]   sb_q[$];
   logic [DW-1:0] seq = 8'h01;

   always #10 clk = ~clk;

   rxwm_dma_trig u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_hiwm(cfg_hiwm), .cfg_error(cfg_error),
      .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof), .overflow(overflow),
      .dma_req(dma_req), .dma_ack(dma_ack), .rd_pop(rd_pop), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_eof(rd_eof)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic put(input bit eof);
      wr_en = 1'b1; wr_data = seq; wr_eof = eof;
      if (m_fill < DEPTH) begin
         sb_q.push_back({eof, seq});
         m_fill++;
      end
      seq = seq + 8'd1;
      tick();
      wr_en = 1'b0; wr_eof = 1'b0;
   endtask

   task automatic put_n(input int n);
      for (int i = 0; i < n; i++) put(1'b0);
   endtask

   task automatic drain();
      dma_ack = 1'b1;
      tick();
      dma_ack = 1'b0;
      rd_pop  = 1'b1;
      for (int i = 0; i < 4 * DEPTH; i++) begin
         tick();
         if (!dma_req) break;
      end
      rd_pop = 1'b0;
      chk(sb_q.size() == 0, "R7 all bytes drained", sb_q.size(), 0);
      chk(dma_req == 1'b0, "R5 req drops after empty", dma_req, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // Scoreboard monitor: compare each popped byte with the expected queue (R6)
   always @(negedge clk) begin
      if (rst_n && rd_pop && rd_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R6 unexpected byte", {rd_eof, rd_data}, 0);
         end else begin
            logic [DW:0] exp_b;
            exp_b = sb_q.pop_front();
            chk({rd_eof, rd_data} == exp_b, "R6 byte order and eof flag",
                {rd_eof, rd_data}, exp_b);
            m_fill--;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk(dma_req == 1'b0, "R1 reset req", dma_req, 0);
      chk(rd_valid == 1'b0, "R1 reset valid", rd_valid, 0);
      chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);
      chk(cfg_error == 1'b0, "R10 legal wm 3", cfg_error, 0);

      // Watermark 3: the trigger falls on the 48th byte
      put_n(47);
      chk(dma_req == 1'b0, "R3 below watermark", dma_req, 0);
      put(1'b0);
      chk(dma_req == 1'b1, "R2 watermark reached", dma_req, 1);
      put_n(2); put(1'b1); put_n(2);
      rd_pop = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(rd_valid == 1'b0, "R8 pop before ack ignored", rd_valid, 0);
      end
      rd_pop = 1'b0;
      chk(dma_req == 1'b1, "R5 req held without ack", dma_req, 1);
      drain();

      // Early end-of-frame (offset now 5)
      put_n(4);
      chk(dma_req == 1'b0, "R3 short frame no eof yet", dma_req, 0);
      put(1'b1);
      chk(dma_req == 1'b1, "R4 eof triggers", dma_req, 1);
      drain();

      // Restart of block count; offset now 10, three boundaries after 38 bytes
      put_n(37);
      chk(dma_req == 1'b0, "R9 count restarted", dma_req, 0);
      put(1'b0);
      chk(dma_req == 1'b1, "R9 fresh watermark", dma_req, 1);
      drain();

      // Watermark 1, offset 0
      cfg_hiwm = 3'd1; tick();
      chk(cfg_error == 1'b0, "R10 legal wm 1", cfg_error, 0);
      put_n(15);
      chk(dma_req == 1'b0, "R3 wm1 below", dma_req, 0);
      put(1'b0);
      chk(dma_req == 1'b1, "R2 wm1 reached", dma_req, 1);
      drain();

      cfg_hiwm = 3'd0; tick();
      chk(cfg_error == 1'b1, "R10 zero wm flagged", cfg_error, 1);
      cfg_hiwm = 3'd7; tick();
      chk(cfg_error == 1'b1, "R10 large wm flagged", cfg_error, 1);
      put_n(47);
      chk(dma_req == 1'b0, "R10 clamp not at 1 or 2 blocks", dma_req, 0);
      put(1'b0);
      chk(dma_req == 1'b1, "R10 clamp to 3 blocks", dma_req, 1);
      drain();
      cfg_hiwm = 3'd3; tick();

      // Overflow: fill all 64, then three dropped writes
      put_n(30); put(1'b1); put_n(33);
      chk(overflow == 1'b0, "R11 full but no drop yet", overflow, 0);
      put_n(3);
      chk(overflow == 1'b1, "R11 drop sets overflow", overflow, 1);
      drain();
      chk(overflow == 1'b1, "R11 overflow sticky", overflow, 1);

      summary();
      $finish;
   end
endmodule